// File: doc/BRIEF.md
# Latency-Matched Pixel Hit Buffer

This block holds digitized hits from one column pair of a pixel readout chip while the first-level trigger decision is still pending. Each incoming hit brings a row address, the crossing count at which its discriminator rose, and the crossing count at which it fell. The block keeps the row and leading-edge time, and turns the two edge times into a time-over-threshold pulse-height value. It places the hit in a free slot of a fixed pool (64 by default). A free-running crossing counter gives the current time.

On every crossing, each stored hit compares its age against a programmable latency, where age is the current time minus its leading edge, modulo 256. A hit whose age equals the latency is kept for readout if the trigger is high in that crossing. Otherwise its slot is released in that same crossing. Kept hits wait in their slots and leave through a valid/ready readout port, one per cycle. Hits from earlier triggers come out first. Hits from the same crossing come out in slot order.

Only pixels with a hit take a slot. When no slot is free, the new hit is lost and a sticky flag records the loss.

Top module: `hit_latency_buffer`

## Requirements
- R1: After reset, `ts` is 0, `rd_valid` is 0, `ovf` is 0 and every slot is free.
- R2: `ts` advances by one on every clock edge, wrapping modulo 256.
- R3: A stored hit keeps its row address unchanged, and its ToT is (`hit_te` - `hit_le`) modulo 256.
- R4: The trigger selects a stored hit when it is high in the cycle where (`ts` - leading edge) mod 256 equals `lat`. That hit is presented on the read port from the next cycle.
- R5: A trigger in any cycle where a hit's age differs from `lat` does not select that hit, and the hit never appears on the read port.
- R6: A hit that reaches its latency with the trigger low frees its slot in that cycle. The slot can take a new hit from the next cycle.
- R7: A hit that arrives while all slots are occupied is discarded, and `ovf` goes to 1. `ovf` stays at 1 until reset.
- R8: A new hit goes to the lowest-numbered free slot. Readout gives hits of an earlier trigger before hits of a later one, regardless of slot numbers. Hits selected by the same trigger come out lowest slot first.
- R9: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid`, `rd_row` and `rd_tot` hold. Each cycle with both high removes exactly one hit.
- R10: `lat` is an 8-bit crossing count that the user can change between hits. It sets the age at which hits are selected or released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lat | input | 8 | Trigger latency in crossings |
| trig | input | 1 | First-level trigger for the current crossing |
| hit_valid | input | 1 | A hit is offered this cycle |
| hit_row | input | 8 | Row address of the hit |
| hit_le | input | 8 | Leading-edge crossing count |
| hit_te | input | 8 | Trailing-edge crossing count |
| rd_ready | input | 1 | Reader takes the presented hit |
| rd_valid | output | 1 | A selected hit is presented |
| rd_row | output | 8 | Row of the presented hit |
| rd_tot | output | 8 | ToT of the presented hit |
| ts | output | 8 | Current crossing count |
| ovf | output | 1 | Sticky lost-hit flag |

## Verification
The embedded assertions check on every cycle that:
- `ovf` never clears once set, and rises only in a cycle with an offered hit;
- a slot becomes pending only in a cycle with the trigger high;
- a pending slot's data does not move;
- writes only land in free slots;
- a stalled read port holds its hit steady.

Whether the right hits are selected at the exact latency, whether unselected ones vanish, and the ordering across triggers and within one crossing can only be shown by the bench's timed scenarios. The same holds for overflow at a full pool and reuse of released slots.

// File: rtl/hbuf_pkg.sv
package hbuf_pkg;

   typedef enum logic [1:0] {
      SLOT_FREE = 2'd0,
      SLOT_WAIT = 2'd1,
      SLOT_PEND = 2'd2
   } slot_state_e;

   function automatic logic [7:0] wrap_diff8(input logic [7:0] a, input logic [7:0] b);
      return a - b;
   endfunction

endpackage

// File: rtl/hbuf_pick.sv
module hbuf_pick #(
   parameter int N  = 64,
   parameter int IW = 6
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);

   if (N < 2) begin : g_bad_n
      $error("hbuf_pick: N must be at least 2");
   end
   if ((1 << IW) < N) begin : g_bad_iw
      $error("hbuf_pick: IW too narrow for N");
   end

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end

endmodule

// File: rtl/hbuf_slot.sv
module hbuf_slot
   import hbuf_pkg::*;
#(
   parameter int ROW_W = 8,
   parameter int TS_W  = 8,
   parameter int TAG_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [ROW_W-1:0] wr_row,
   input  logic [TS_W-1:0]  wr_le,
   input  logic [TS_W-1:0]  wr_tot,
   input  logic [TS_W-1:0]  cur_ts,
   input  logic [TS_W-1:0]  lat,
   input  logic             trig,
   input  logic [TAG_W-1:0] new_tag,
   input  logic [TAG_W-1:0] head_tag,
   input  logic             pop,
   output logic             busy,
   output logic             ready,
   output logic             sel_now,
   output logic [ROW_W-1:0] row,
   output logic [TS_W-1:0]  tot
);

   slot_state_e      state_q;
   logic [ROW_W-1:0] row_q;
   logic [TS_W-1:0]  le_q;
   logic [TS_W-1:0]  tot_q;
   logic [TAG_W-1:0] tag_q;
   logic [TS_W-1:0]  age;
   logic             at_lat;
   logic             pend;

   assign age     = cur_ts - le_q;
   assign at_lat  = (state_q == SLOT_WAIT) && (age == lat);
   assign sel_now = at_lat && trig;
   assign pend    = (state_q == SLOT_PEND);
   assign busy    = (state_q != SLOT_FREE);
   assign ready   = pend && (tag_q == head_tag);
   assign row     = row_q;
   assign tot     = tot_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SLOT_FREE;
         row_q   <= '0;
         le_q    <= '0;
         tot_q   <= '0;
         tag_q   <= '0;
      end else if (wr) begin
         state_q <= SLOT_WAIT;
         row_q   <= wr_row;
         le_q    <= wr_le;
         tot_q   <= wr_tot;
      end else if (at_lat) begin
         state_q <= trig ? SLOT_PEND : SLOT_FREE;
         tag_q   <= new_tag;
      end else if (pop && pend) begin
         state_q <= SLOT_FREE;
      end
   end

   // R8
   wr_free_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |-> !busy);

   // R4
   pend_needs_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> $past(trig));

   // R9
   pend_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !pop) |=> (pend && $stable(row_q) && $stable(tot_q)));

endmodule

// File: rtl/hit_latency_buffer.sv
module hit_latency_buffer
   import hbuf_pkg::*;
#(
   parameter int NBUF  = 64,
   parameter int ROW_W = 8,
   parameter int TS_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TS_W-1:0]  lat,
   input  logic             trig,
   input  logic             hit_valid,
   input  logic [ROW_W-1:0] hit_row,
   input  logic [TS_W-1:0]  hit_le,
   input  logic [TS_W-1:0]  hit_te,
   input  logic             rd_ready,
   output logic             rd_valid,
   output logic [ROW_W-1:0] rd_row,
   output logic [TS_W-1:0]  rd_tot,
   output logic [TS_W-1:0]  ts,
   output logic             ovf
);

   localparam int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1;
   localparam int TAG_W = IDX_W + 1;

   if (NBUF < 2) begin : g_bad_nbuf
      $error("hit_latency_buffer: NBUF must be at least 2");
   end
   if (TS_W < 2) begin : g_bad_ts
      $error("hit_latency_buffer: TS_W must be at least 2");
   end
   if (ROW_W < 1) begin : g_bad_row
      $error("hit_latency_buffer: ROW_W must be positive");
   end

   logic [TS_W-1:0]  ts_q;
   logic             ovf_q;
   logic [TAG_W-1:0] head_q;
   logic [TAG_W-1:0] tail_q;

   logic [NBUF-1:0]  busy_v;
   logic [NBUF-1:0]  ready_v;
   logic [NBUF-1:0]  sel_v;
   logic [NBUF-1:0]  wr_v;
   logic [NBUF-1:0]  pop_v;
   logic [ROW_W-1:0] row_a [NBUF];
   logic [TS_W-1:0]  tot_a [NBUF];

   logic             free_any;
   logic [IDX_W-1:0] free_idx;
   logic             rd_any;
   logic [IDX_W-1:0] rd_idx;
   logic             take;
   logic             full;
   logic [TS_W-1:0]  tot_in;

   assign tot_in = wrap_diff8(8'(hit_te), 8'(hit_le));
   assign full   = &busy_v;
   assign take   = rd_any && rd_ready;

   hbuf_pick #(.N(NBUF), .IW(IDX_W)) u_alloc (
      .req   (~busy_v),
      .found (free_any),
      .idx   (free_idx)
   );

   hbuf_pick #(.N(NBUF), .IW(IDX_W)) u_rdsel (
      .req   (ready_v),
      .found (rd_any),
      .idx   (rd_idx)
   );

   for (genvar g = 0; g < NBUF; g++) begin : g_slot
      assign wr_v[g]  = hit_valid && free_any && (free_idx == IDX_W'(g));
      assign pop_v[g] = take && (rd_idx == IDX_W'(g));

      hbuf_slot #(.ROW_W(ROW_W), .TS_W(TS_W), .TAG_W(TAG_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr       (wr_v[g]),
         .wr_row   (hit_row),
         .wr_le    (hit_le),
         .wr_tot   (tot_in),
         .cur_ts   (ts_q),
         .lat      (lat),
         .trig     (trig),
         .new_tag  (tail_q),
         .head_tag (head_q),
         .pop      (pop_v[g]),
         .busy     (busy_v[g]),
         .ready    (ready_v[g]),
         .sel_now  (sel_v[g]),
         .row      (row_a[g]),
         .tot      (tot_a[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ts_q   <= '0;
         ovf_q  <= 1'b0;
         head_q <= '0;
         tail_q <= '0;
      end else begin
         ts_q <= ts_q + 1'b1;
         if (hit_valid && !free_any) begin
            ovf_q <= 1'b1;
         end
         if (|sel_v) begin
            tail_q <= tail_q + 1'b1;
         end
         if (!rd_any && (head_q != tail_q)) begin
            head_q <= head_q + 1'b1;
         end
      end
   end

   assign ts       = ts_q;
   assign ovf      = ovf_q;
   assign rd_valid = rd_any;
   assign rd_row   = row_a[rd_idx];
   assign rd_tot   = tot_a[rd_idx];

   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);

   // R7
   ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> ($past(hit_valid) && $past(full)));

   // R9
   rd_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_row) && $stable(rd_tot)));

   // R8
   rd_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (ready_v[rd_idx] && $onehot0(pop_v)));

endmodule

// File: tb/sim_hit_latency_buffer.sv
module sim_hit_latency_buffer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] lat = 8'd3;
   logic       trig = 1'b0;
   logic       hit_valid = 1'b0;
   logic [7:0] hit_row = '0;
   logic [7:0] hit_le = '0;
   logic [7:0] hit_te = '0;
   logic       rd_ready = 1'b0;
   logic       rd_valid;
   logic [7:0] rd_row;
   logic [7:0] rd_tot;
   logic [7:0] ts;
   logic       ovf;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   hit_latency_buffer u0 (
      .clk(clk), .rst_n(rst_n), .lat(lat), .trig(trig),
      .hit_valid(hit_valid), .hit_row(hit_row), .hit_le(hit_le), .hit_te(hit_te),
      .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_row(rd_row), .rd_tot(rd_tot),
      .ts(ts), .ovf(ovf)
   );

   typedef struct packed {
      logic [7:0] lat;
      logic [7:0] toff;
      logic [7:0] tot;
      logic [7:0] row;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VEC [NV] = '{
      '{lat: 8'd3,  toff: 8'd3,  tot: 8'd5,   row: 8'h11},
      '{lat: 8'd3,  toff: 8'd2,  tot: 8'd7,   row: 8'h12},
      '{lat: 8'd3,  toff: 8'd4,  tot: 8'd9,   row: 8'h13},
      '{lat: 8'd12, toff: 8'd12, tot: 8'd0,   row: 8'h33},
      '{lat: 8'd40, toff: 8'd40, tot: 8'd255, row: 8'hA5},
      '{lat: 8'd1,  toff: 8'd1,  tot: 8'd128, row: 8'hFE},
      '{lat: 8'd12, toff: 8'd11, tot: 8'd20,  row: 8'h34}
   };

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input int act, input int exp, input string what);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic put_hit(input logic [7:0] row, input logic [7:0] le, input logic [7:0] tot);
      hit_valid = 1'b1;
      hit_row   = row;
      hit_le    = le;
      hit_te    = le + tot;
   endtask

   task automatic take(input logic [7:0] erow, input logic [7:0] etot, input string req);
      int w = 0;
      while (!rd_valid && w < 4) begin
         step();
         w++;
      end
      chk(int'(rd_valid), 1, {req, " rd_valid"});
      if (rd_valid) begin
         chk(int'(rd_row), int'(erow), {req, " rd_row"});
         chk(int'(rd_tot), int'(etot), {req, " rd_tot"});
         rd_ready = 1'b1;
         step();
         rd_ready = 1'b0;
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] x;
      @(negedge clk);
      step();
      // R1 reset state
      chk(int'(ts), 0, "R1 ts");
      chk(int'(rd_valid), 0, "R1 rd_valid");
      chk(int'(ovf), 0, "R1 ovf");
      rst_n = 1'b1;
      step();
      // R2 counter
      x = ts;
      repeat (5) step();
      chk(int'(ts), int'(8'(x + 8'd5)), "R2 ts advance");

      // table walk: R3 R4 R5 R10
      for (int k = 0; k < NV; k++) begin
         lat = VEC[k].lat;
         x = ts;
         put_hit(VEC[k].row, x, VEC[k].tot);
         step();
         hit_valid = 1'b0;
         repeat (int'(VEC[k].toff) - 1) step();
         trig = 1'b1;
         step();
         trig = 1'b0;
         if (VEC[k].toff == VEC[k].lat) begin
            take(VEC[k].row, VEC[k].tot, "R4 R3 R10 vector");
         end else begin
            chk(int'(rd_valid), 0, "R5 off-latency trigger");
         end
         repeat (int'(VEC[k].lat) + 4) step();
         chk(int'(rd_valid), 0, "R5 nothing left");
      end

      // R8 R6 R9: older trigger first even from a higher slot
      lat = 8'd6;
      x = ts;
      put_hit(8'h41, x, 8'd1); step();
      put_hit(8'h42, x + 8'd1, 8'd2); step();
      put_hit(8'h43, x + 8'd2, 8'd3); step();
      hit_valid = 1'b0;
      repeat (4) step();
      put_hit(8'h44, x + 8'd7, 8'd4);
      trig = 1'b1;
      step();
      hit_valid = 1'b0;
      chk(int'(rd_valid), 1, "R4 second hit selected");
      chk(int'(rd_row), 8'h42, "R4 selected row");
      step();
      trig = 1'b0;
      chk(int'(rd_valid), 1, "R9 stall valid");
      chk(int'(rd_row), 8'h42, "R9 stall row");
      repeat (4) step();
      trig = 1'b1;
      step();
      trig = 1'b0;
      take(8'h42, 8'd2, "R8 first trigger");
      take(8'h43, 8'd3, "R8 second trigger");
      take(8'h44, 8'd4, "R8 R6 third trigger in reused slot");
      repeat (3) step();
      chk(int'(rd_valid), 0, "R5 R6 untriggered hit absent");

      // R8 same crossing: lowest slot first
      x = ts;
      put_hit(8'h51, x, 8'd6); step();
      put_hit(8'h52, x, 8'd8); step();
      hit_valid = 1'b0;
      repeat (4) step();
      trig = 1'b1;
      step();
      trig = 1'b0;
      take(8'h51, 8'd6, "R8 same crossing slot0");
      take(8'h52, 8'd8, "R8 same crossing slot1");

      // R7 R6 overflow and reuse
      lat = 8'd100;
      x = ts;
      for (int i = 0; i < 64; i++) begin
         put_hit(8'(i), x + 8'(i), 8'd1);
         step();
      end
      chk(int'(ovf), 0, "R7 no overflow at 64");
      put_hit(8'd99, x + 8'd64, 8'd2);
      step();
      hit_valid = 1'b0;
      chk(int'(ovf), 1, "R7 overflow set");
      repeat (99) step();
      trig = 1'b1;
      step();
      trig = 1'b0;
      chk(int'(rd_valid), 0, "R7 dropped hit absent");
      chk(int'(ovf), 1, "R7 overflow sticky");
      x = ts;
      put_hit(8'h77, x, 8'd9);
      step();
      hit_valid = 1'b0;
      repeat (99) step();
      trig = 1'b1;
      step();
      trig = 1'b0;
      take(8'h77, 8'd9, "R6 released slots reusable");

      // R1 reset clears overflow
      rst_n = 1'b0;
      step();
      step();
      chk(int'(ovf), 0, "R1 ovf after reset");
      chk(int'(ts), 0, "R1 ts after reset");
      chk(int'(rd_valid), 0, "R1 rd_valid after reset");
      finish_run();
   end

endmodule